// File: doc/BRIEF.md
# Strobe-Gated Framed Serial Receiver

This block takes words from a measurement instrument over a source-synchronous serial link. The link has three lines: a data bit, a forwarded clock of 75 MHz or more, and an active-low strobe. The strobe marks the cycles in which the data line carries meaning. The line buffers sit outside the block, so it sees plain single-ended signals.

A receive state machine runs directly on the forwarded clock. It samples data on each rising edge while the strobe is low. It hunts for a start bit, shifts in a 16-bit payload with the most significant bit first, and then checks two closing bits. A good frame is loaded into a holding register and passed to the system clock domain through a toggle handshake. There it appears on a parallel output together with a one-cycle valid pulse. A frame whose closing bits are wrong is not delivered. It sets a sticky error flag instead, which the system side clears.

The state machine has four states:

- `ST_IDLE`: the strobe is high.
- `ST_HUNT`: the strobe is low and the block is waiting for the start bit.
- `ST_PAYLOAD`: the 16 payload bits are being shifted in.
- `ST_TAIL`: the two closing bits are being checked.

Its transitions:

- IDLE to PAYLOAD: the strobe is low and data is 1.
- IDLE to HUNT: the strobe is low and data is 0.
- HUNT to PAYLOAD: data is 1.
- PAYLOAD to TAIL: after the 16th bit.
- TAIL to HUNT: after the 2nd closing bit.
- Any non-idle state to IDLE: the strobe is seen high.

Top module: `sfr_receiver`

## Requirements
- R1: The link inputs are sampled only on rising `lclk` edges where `ser_strb_n` is 0. While `ser_strb_n` is 1, data values (including 1s) start no frame, and the receiver sits in `ST_IDLE`.
- R2: While the strobe is low and no frame is in progress, any number of 0 bits before the start bit (value 1) are skipped.
- R3: A frame consists of three parts, in this order:
  - a start bit of 1;
  - 16 payload bits, the most significant bit first;
  - two closing bits, both 0.
  
  A frame with both closing bits at 0 appears on `word_out`, and `word_vld` is 1 for exactly one `sclk` cycle.
- R4: If the strobe goes high while in `ST_HUNT`, `ST_PAYLOAD` or `ST_TAIL`, the frame is abandoned. The receiver returns to `ST_IDLE`, no word is delivered, and `frame_err` is not set. The next frame is received normally.
- R5: If either closing bit is 1, the payload is dropped, with no `word_vld` pulse. `frame_err` then goes to 1 and stays at 1 until it is cleared, even while later good frames are delivered.
- R6: `err_clr` sampled high on an `sclk` edge clears `frame_err`. If a bad frame arrives in the same cycle, setting the flag takes priority.
- R7: After the second closing bit, the receiver hunts again at once. Frames may therefore follow each other under one continuous strobe, and each word is delivered exactly once, in order.
- R8: Each finished frame crosses to `sclk` through a request/acknowledge toggle handshake with `SYNC_STAGES` synchroniser flops on each side. The round trip must fit inside one minimum frame of 19 link cycles. Given that, no frame finishes while the previous transfer is still pending.
- R9: After reset, `word_out` is 0, `word_vld` is 0 and `frame_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Forwarded link clock |
| lrst_n | input | 1 | Asynchronous active-low reset, link domain |
| ser_data | input | 1 | Serial data line |
| ser_strb_n | input | 1 | Active-low strobe qualifying data |
| sclk | input | 1 | System clock |
| srst_n | input | 1 | Asynchronous active-low reset, system domain |
| err_clr | input | 1 | Clears the sticky framing-error flag |
| word_out | output | 16 | Last delivered payload |
| word_vld | output | 1 | One-cycle pulse when `word_out` is new |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench probes several corner cases, each tied to a fault it would reveal:

- **Strobe high with data at 1.** A receiver that ignores the strobe would lock onto a phantom start bit and emit garbage.
- **Long run of zeros before the start bit.** A hunter that counts from the strobe edge would misalign the payload.
- **Frames aborted in each of the hunting, payload and closing phases, each followed by a good frame.** A receiver that keeps its bit counter or error bit after an abort would deliver a shifted or rejected word.
- **Frames sent back to back under one strobe.** These expose an off-by-one return to hunting, as well as a handshake that loses or repeats words.
- **Closing-bit faults in the first and in the second position.** A check that looks at only one closing bit would let a bad word through.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_TAIL    = 2'd3
    } rx_state_e;

    localparam logic START_LEVEL = 1'b1;
    localparam logic TAIL_LEVEL  = 1'b0;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_link_fsm.sv
module sfr_link_fsm
    import sfr_pkg::*;
#(
    parameter int PAYLOAD_W = 16,
    parameter int TAIL_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sd,
    input  logic                 strb_n,
    output logic                 done,
    output logic                 bad,
    output logic [PAYLOAD_W-1:0] word
);
    localparam int MAXB  = (PAYLOAD_W > TAIL_BITS) ? PAYLOAD_W : TAIL_BITS;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(PAYLOAD_W - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_BITS - 1);

    rx_state_e              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q;
    logic [PAYLOAD_W-1:0]   shreg_q;
    logic                   tail_bad_q;
    logic                   sample;
    logic                   tail_ok_bit;
    logic                   last_tail;

    assign sample      = !strb_n;
    assign tail_ok_bit = (sd == TAIL_LEVEL);
    assign last_tail   = (state_q == ST_TAIL) && sample && (cnt_q == TAIL_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sample) state_d = (sd == START_LEVEL) ? ST_PAYLOAD : ST_HUNT;
            end
            ST_HUNT: begin
                if (!sample)                 state_d = ST_IDLE;
                else if (sd == START_LEVEL)  state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (!sample)                 state_d = ST_IDLE;
                else if (cnt_q == PAY_LAST)  state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (!sample)                 state_d = ST_IDLE;
                else if (cnt_q == TAIL_LAST) state_d = ST_HUNT;
            end
        endcase
    end

    // bit counter, shift register, closing-bit check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shreg_q    <= '0;
            tail_bad_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HUNT: begin
                    cnt_q      <= '0;
                    tail_bad_q <= 1'b0;
                end
                ST_PAYLOAD: begin
                    if (sample) begin
                        shreg_q <= {shreg_q[PAYLOAD_W-2:0], sd};
                        cnt_q   <= (cnt_q == PAY_LAST) ? '0 : cnt_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (sample) begin
                        cnt_q      <= (cnt_q == TAIL_LAST) ? '0 : cnt_q + 1'b1;
                        tail_bad_q <= tail_bad_q | !tail_ok_bit;
                    end
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            bad  <= 1'b0;
            word <= '0;
        end else begin
            done <= last_tail;
            if (last_tail) begin
                bad  <= tail_bad_q | !tail_ok_bit;
                word <= shreg_q;
            end
        end
    end
endmodule

// File: rtl/sfr_link_tx.sv
module sfr_link_tx #(
    parameter int PAYLOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic                 bad,
    input  logic [PAYLOAD_W-1:0] word,
    output logic                 req_t,
    output logic                 hold_bad,
    output logic [PAYLOAD_W-1:0] hold_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_t     <= 1'b0;
            hold_bad  <= 1'b0;
            hold_word <= '0;
        end else if (done) begin
            req_t     <= ~req_t;
            hold_bad  <= bad;
            hold_word <= word;
        end
    end
endmodule

// File: rtl/sfr_sys_side.sv
module sfr_sys_side #(
    parameter int PAYLOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_s,
    input  logic                 hold_bad,
    input  logic [PAYLOAD_W-1:0] hold_word,
    input  logic                 err_clr,
    output logic                 ack_t,
    output logic [PAYLOAD_W-1:0] word_out,
    output logic                 word_vld,
    output logic                 frame_err
);
    logic seen_q;
    logic rec_new;

    assign rec_new = req_s ^ seen_q;
    assign ack_t   = seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out  <= '0;
            word_vld  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            word_vld <= rec_new & ~hold_bad;
            if (rec_new & ~hold_bad) word_out <= hold_word;
            if (rec_new & hold_bad)  frame_err <= 1'b1;
            else if (err_clr)        frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/sfr_receiver.sv
module sfr_receiver #(
    parameter int PAYLOAD_W   = 16,
    parameter int TAIL_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 lclk,
    input  logic                 lrst_n,
    input  logic                 ser_data,
    input  logic                 ser_strb_n,
    input  logic                 sclk,
    input  logic                 srst_n,
    input  logic                 err_clr,
    output logic [PAYLOAD_W-1:0] word_out,
    output logic                 word_vld,
    output logic                 frame_err
);
    logic                 frame_done;
    logic                 frame_bad;
    logic [PAYLOAD_W-1:0] frame_word;
    logic                 req_t;
    logic                 ack_t;
    logic                 req_s;
    logic                 ack_l;
    logic                 hold_bad;
    logic [PAYLOAD_W-1:0] hold_word;

    sfr_link_fsm #(.PAYLOAD_W(PAYLOAD_W), .TAIL_BITS(TAIL_BITS)) u_fsm (
        .clk    (lclk),
        .rst_n  (lrst_n),
        .sd     (ser_data),
        .strb_n (ser_strb_n),
        .done   (frame_done),
        .bad    (frame_bad),
        .word   (frame_word)
    );

    sfr_link_tx #(.PAYLOAD_W(PAYLOAD_W)) u_tx (
        .clk       (lclk),
        .rst_n     (lrst_n),
        .done      (frame_done),
        .bad       (frame_bad),
        .word      (frame_word),
        .req_t     (req_t),
        .hold_bad  (hold_bad),
        .hold_word (hold_word)
    );

    sfr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (sclk),
        .rst_n (srst_n),
        .d     (req_t),
        .q     (req_s)
    );

    sfr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (lclk),
        .rst_n (lrst_n),
        .d     (ack_t),
        .q     (ack_l)
    );

    sfr_sys_side #(.PAYLOAD_W(PAYLOAD_W)) u_sys (
        .clk       (sclk),
        .rst_n     (srst_n),
        .req_s     (req_s),
        .hold_bad  (hold_bad),
        .hold_word (hold_word),
        .err_clr   (err_clr),
        .ack_t     (ack_t),
        .word_out  (word_out),
        .word_vld  (word_vld),
        .frame_err (frame_err)
    );
endmodule

// File: rtl/sfr_receiver_chk.sv
module sfr_receiver_chk (
    input logic lclk,
    input logic lrst_n,
    input logic sclk,
    input logic srst_n,
    input logic ser_strb_n,
    input logic frame_done,
    input logic req_t,
    input logic ack_l,
    input logic req_s,
    input logic ack_t,
    input logic hold_bad,
    input logic word_vld,
    input logic frame_err,
    input logic err_clr
);
    logic rec_new;
    assign rec_new = req_s ^ ack_t;

    AST_STROBE_HIGH_NO_DONE: assert property (@(posedge lclk) disable iff (!lrst_n)
        ser_strb_n |=> !frame_done); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge lclk) disable iff (!lrst_n)
        frame_done |=> !frame_done); // R7
    AST_NO_OVERRUN: assert property (@(posedge lclk) disable iff (!lrst_n)
        frame_done |-> (req_t == ack_l)); // R8
    AST_VLD_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!srst_n)
        word_vld |=> !word_vld); // R3
    AST_BAD_NO_VLD: assert property (@(posedge sclk) disable iff (!srst_n)
        (rec_new && hold_bad) |=> (!word_vld && frame_err)); // R5
    AST_ERR_STICKY: assert property (@(posedge sclk) disable iff (!srst_n)
        (frame_err && !err_clr) |=> frame_err); // R5
    AST_ERR_CLEAR: assert property (@(posedge sclk) disable iff (!srst_n)
        (err_clr && !(rec_new && hold_bad)) |=> !frame_err); // R6
    AST_ERR_CAUSE: assert property (@(posedge sclk) disable iff (!srst_n)
        $rose(frame_err) |-> $past(rec_new && hold_bad)); // R5
endmodule

bind sfr_receiver sfr_receiver_chk u_chk (
    .lclk       (lclk),
    .lrst_n     (lrst_n),
    .sclk       (sclk),
    .srst_n     (srst_n),
    .ser_strb_n (ser_strb_n),
    .frame_done (frame_done),
    .req_t      (req_t),
    .ack_l      (ack_l),
    .req_s      (req_s),
    .ack_t      (ack_t),
    .hold_bad   (hold_bad),
    .word_vld   (word_vld),
    .frame_err  (frame_err),
    .err_clr    (err_clr)
);

// File: tb/sfr_receiver_test.sv
`timescale 1ns/1ps
module sfr_receiver_test;
    logic        lclk = 1'b0;
    logic        sclk = 1'b0;
    logic        lrst_n = 1'b0;
    logic        srst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_strb_n = 1'b1;
    logic        err_clr = 1'b0;
    logic [15:0] word_out;
    logic        word_vld;
    logic        frame_err;

    int tests = 0;
    int fails = 0;
    int got_cnt = 0;
    bit finished = 0;
    bit prev_vld = 0;
    logic [15:0] exp_q[$];

    always #2.5 sclk = ~sclk;   // 200 MHz system clock
    always #3.0 lclk = ~lclk;   // link clock

    sfr_receiver uut (
        .lclk(lclk), .lrst_n(lrst_n), .ser_data(ser_data), .ser_strb_n(ser_strb_n),
        .sclk(sclk), .srst_n(srst_n), .err_clr(err_clr),
        .word_out(word_out), .word_vld(word_vld), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge sclk) begin
        if (srst_n) begin
            if (word_vld && prev_vld)
                check(0, "R3", "valid longer than one cycle", 32'd2, 32'd1);
            if (word_vld) begin
                got_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected word", {16'd0, word_out}, 32'd0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(word_out == e, "R3", "delivered word", {16'd0, word_out}, {16'd0, e});
                end
            end
            prev_vld = word_vld;
        end
    end

    task automatic link_bit(input logic strb_n, input logic d);
        @(negedge lclk);
        ser_strb_n = strb_n;
        ser_data   = d;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) link_bit(1'b1, i[0]);
    endtask

    // driver: pushes expected words
    task automatic send_frame(input logic [15:0] p, input logic e0, input logic e1,
                              input int pre_zeros);
        for (int i = 0; i < pre_zeros; i++) link_bit(1'b0, 1'b0);
        link_bit(1'b0, 1'b1);
        for (int i = 15; i >= 0; i--) link_bit(1'b0, p[i]);
        if (!e0 && !e1) exp_q.push_back(p);
        link_bit(1'b0, e0);
        link_bit(1'b0, e1);
    endtask

    task automatic drain(input string req);
        idle_cycles(24);
        check(exp_q.size() == 0, req, "words outstanding", exp_q.size(), 32'd0);
    endtask

    task automatic pulse_clr;
        @(negedge sclk); err_clr = 1'b1;
        @(negedge sclk); err_clr = 1'b0;
        @(negedge sclk);
    endtask

    initial begin
        repeat (4) @(negedge sclk);
        lrst_n = 1'b1; srst_n = 1'b1;
        @(negedge sclk);
        check(word_vld == 0, "R9", "reset word_vld", word_vld, 0);
        check(frame_err == 0, "R9", "reset frame_err", frame_err, 0);
        check(word_out == 0, "R9", "reset word_out", word_out, 0);

        // R1: data toggling while strobe high starts nothing
        idle_cycles(40);
        check(got_cnt == 0, "R1", "words while strobe high", got_cnt, 0);
        check(frame_err == 0, "R1", "error while strobe high", frame_err, 0);

        // R3: plain frame
        send_frame(16'hA5C3, 0, 0, 0);
        drain("R3");
        // R2: leading zeros
        send_frame(16'h0001, 0, 0, 7);
        drain("R2");
        // R7: back to back under one strobe
        send_frame(16'hFFFF, 0, 0, 0);
        send_frame(16'h0000, 0, 0, 0);
        send_frame(16'h8001, 0, 0, 2);
        drain("R7");

        // R4: abort in payload
        link_bit(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) link_bit(1'b0, 1'b1);
        idle_cycles(3);
        send_frame(16'h1234, 0, 0, 0);
        drain("R4");
        // R4: abort in closing phase
        link_bit(1'b0, 1'b1);
        for (int i = 0; i < 16; i++) link_bit(1'b0, i[0]);
        link_bit(1'b0, 1'b0);
        idle_cycles(3);
        // R4: abort in hunting
        link_bit(1'b0, 1'b0);
        link_bit(1'b0, 1'b0);
        idle_cycles(3);
        send_frame(16'h4321, 0, 0, 1);
        drain("R4");
        check(frame_err == 0, "R4", "abort raised error", frame_err, 0);
        check(got_cnt == 7, "R4", "delivered count", got_cnt, 7);

        // R5: first closing bit wrong
        send_frame(16'hDEAD, 1, 0, 0);
        drain("R5");
        check(frame_err == 1, "R5", "error after bad first closing bit", frame_err, 1);
        check(got_cnt == 7, "R5", "bad word delivered", got_cnt, 7);
        send_frame(16'h0F0F, 0, 0, 0);
        drain("R5");
        check(frame_err == 1, "R5", "error not sticky", frame_err, 1);
        pulse_clr();
        check(frame_err == 0, "R6", "error after clear", frame_err, 0);
        // R5: second closing bit wrong
        send_frame(16'hBEEF, 0, 1, 0);
        drain("R5");
        check(frame_err == 1, "R5", "error after bad second closing bit", frame_err, 1);
        check(got_cnt == 8, "R5", "delivered count", got_cnt, 8);
        pulse_clr();
        check(frame_err == 0, "R6", "error after second clear", frame_err, 0);

        // R8: continuous stream through the handshake
        for (int k = 0; k < 8; k++) send_frame(16'h1357 ^ (16'(k) * 16'h2F11), 0, 0, 0);
        drain("R8");
        check(got_cnt == 16, "R8", "stream delivered count", got_cnt, 16);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sclk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule